// File: doc/BRIEF.md
# Subsleep Power-State Controller

This controller decides when a small microcontroller core may drop from running on its subclock into a low-power subsleep condition, and when it must come back. The CPU signals that it has executed a sleep instruction; the controller looks at three configuration bits taken from the system control registers and only goes to sleep for one exact combination of them. While asleep, the CPU clock is gated, the A/D converter and PWM unit are switched off, every other peripheral keeps running, and a hold-enable output tells register files, RAM and I/O pads to keep their state.

Wake-up comes from a vector of interrupt requests (timers, event counter, serial port, external IRQ lines and wake-up pins), each with its own enable bit, all qualified by a global interrupt mask. A qualified request passes through a two-flop synchronizer on the subclock before the controller reopens the CPU clock and pulses the exception-start output for one cycle. Pulling the reset pin low ends subsleep at once and returns everything to the running state.

States: `ST_RUN` (subactive, CPU clocked), `ST_DOZE` (subsleep), `ST_WAKE` (one-cycle exception start). Transitions: `ST_RUN -> ST_DOZE` on sleep strobe with matching configuration; `ST_DOZE -> ST_WAKE` when the synchronized qualified request is high; `ST_WAKE -> ST_RUN` unconditionally; any state `-> ST_RUN` on reset low.

Top module: `sslp_ctrl`

## Requirements
- R1: While and right after reset, cpu_clk_en is 1, periph_en is all ones, hold_en is 0 and exc_start is 0.
- R2: In ST_RUN, sleep_exec high with cfg_stby=0, cfg_lspd=1 and cfg_tclk=1 at a rising edge moves to subsleep, seen after that edge as cpu_clk_en=0.
- R3: A sleep strobe with any other configuration combination is ignored and cpu_clk_en stays 1.
- R4: In subsleep, cpu_clk_en is 0 and periph_en has bit 0 (A/D) and bit 1 (PWM) at 0 while all other bits stay 1.
- R5: In subsleep hold_en is 1; in every other state it is 0.
- R6: A request is qualified when irq_mask is 0 and some bit i has irq_req[i] and irq_en[i] both 1; a held qualified request ends subsleep.
- R7: With irq_mask at 1, or with no requesting source enabled, subsleep is not left.
- R8: A qualified request applied before a rising edge leaves the controller asleep after the first two edges; exc_start goes high after the third edge.
- R9: exc_start is high for exactly one cycle, with cpu_clk_en=1 and full periph_en, and the controller is in ST_RUN on the next cycle.
- R10: rst_n low ends subsleep immediately, without waiting for a clock, giving the R1 output values and no exc_start pulse.
- R11: sleep_exec asserted while already in subsleep has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Subclock |
| rst_n | input | 1 | Active-low reset pin, asynchronous |
| sleep_exec | input | 1 | Sleep instruction executed strobe |
| cfg_stby | input | 1 | Standby-select configuration bit |
| cfg_lspd | input | 1 | Low-speed-on configuration bit |
| cfg_tclk | input | 1 | Timer clock-select configuration bit |
| irq_mask | input | 1 | Global interrupt mask, 1 blocks wake |
| irq_req | input | 18 | Per-source interrupt requests |
| irq_en | input | 18 | Per-source interrupt enables |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_en | output | 8 | Peripheral enables, bit 0 A/D, bit 1 PWM |
| hold_en | output | 1 | Retention hold for registers, RAM and pads |
| exc_start | output | 1 | One-cycle start of interrupt exception handling |

## Verification
Entry is tried with all eight configuration combinations under random strobes, which separates the one accepted combination from the seven that must be ignored. In subsleep the request, enable and mask vectors are randomized, so cases where a source requests without enable, is enabled without requesting, or is masked globally are told apart from true wake events. Directed cases pin the synchronizer latency edge by edge, the single-cycle width of the exception pulse, a strobe arriving while already asleep, and an asynchronous reset in the middle of subsleep.

// File: rtl/sslp_pkg.sv
package sslp_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_DOZE = 2'd1,
        ST_WAKE = 2'd2
    } sslp_state_t;

    typedef struct packed {
        logic cpu_clk_en;
        logic hold_en;
        logic exc_start;
        logic periph_gate;
    } sslp_ctl_t;

endpackage

// File: rtl/sslp_entry_match.sv
module sslp_entry_match (
    input  logic cfg_stby,
    input  logic cfg_lspd,
    input  logic cfg_tclk,
    input  logic sleep_exec,
    output logic enter_req
);
    // Only one configuration combination selects subsleep.
    logic cfg_match;

    always_comb begin
        cfg_match = (~cfg_stby) & cfg_lspd & cfg_tclk;
        enter_req = sleep_exec & cfg_match;
    end
endmodule

// File: rtl/sslp_wake_qual.sv
module sslp_wake_qual #(
    parameter int NUM_SRC = 18
) (
    input  logic               irq_mask,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [NUM_SRC-1:0] irq_en,
    output logic               wake_raw
);
    logic [NUM_SRC-1:0] live;

    always_comb begin
        live     = irq_req & irq_en;
        wake_raw = (|live) & ~irq_mask;
    end
endmodule

// File: rtl/sslp_sync.sv
module sslp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/sslp_fsm.sv
module sslp_fsm
    import sslp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enter_req,
    input  logic        wake_sync,
    output sslp_state_t state,
    output sslp_ctl_t   ctl
);
    sslp_state_t state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  if (enter_req) state_nx = ST_DOZE;
            ST_DOZE: if (wake_sync) state_nx = ST_WAKE;
            ST_WAKE: state_nx = ST_RUN;
            default: state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        ctl = '{cpu_clk_en: 1'b1, hold_en: 1'b0, exc_start: 1'b0, periph_gate: 1'b0};
        unique case (state)
            ST_RUN:  ;
            ST_DOZE: begin
                ctl.cpu_clk_en  = 1'b0;
                ctl.hold_en     = 1'b1;
                ctl.periph_gate = 1'b1;
            end
            ST_WAKE: ctl.exc_start = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sslp_ctrl.sv
module sslp_ctrl
    import sslp_pkg::*;
#(
    parameter int NUM_SRC    = 18,
    parameter int NUM_PERIPH = 8,
    parameter int ADC_IDX    = 0,
    parameter int PWM_IDX    = 1,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sleep_exec,
    input  logic                  cfg_stby,
    input  logic                  cfg_lspd,
    input  logic                  cfg_tclk,
    input  logic                  irq_mask,
    input  logic [NUM_SRC-1:0]    irq_req,
    input  logic [NUM_SRC-1:0]    irq_en,
    output logic                  cpu_clk_en,
    output logic [NUM_PERIPH-1:0] periph_en,
    output logic                  hold_en,
    output logic                  exc_start
);
    localparam logic [NUM_PERIPH-1:0] GATED_SET =
        (NUM_PERIPH'(1) << ADC_IDX) | (NUM_PERIPH'(1) << PWM_IDX);

    logic        enter_req;
    logic        wake_raw;
    logic        wake_sync;
    sslp_state_t state;
    sslp_ctl_t   ctl;

    sslp_entry_match u_entry (
        .cfg_stby   (cfg_stby),
        .cfg_lspd   (cfg_lspd),
        .cfg_tclk   (cfg_tclk),
        .sleep_exec (sleep_exec),
        .enter_req  (enter_req)
    );

    sslp_wake_qual #(.NUM_SRC(NUM_SRC)) u_qual (
        .irq_mask (irq_mask),
        .irq_req  (irq_req),
        .irq_en   (irq_en),
        .wake_raw (wake_raw)
    );

    sslp_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (wake_raw),
        .d_out (wake_sync)
    );

    sslp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter_req (enter_req),
        .wake_sync (wake_sync),
        .state     (state),
        .ctl       (ctl)
    );

    always_comb begin
        cpu_clk_en = ctl.cpu_clk_en;
        hold_en    = ctl.hold_en;
        exc_start  = ctl.exc_start;
        periph_en  = ctl.periph_gate ? ~GATED_SET : '1;
    end
endmodule

// File: rtl/sslp_ctrl_chk.sv
module sslp_ctrl_chk #(
    parameter int NUM_SRC    = 18,
    parameter int NUM_PERIPH = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sleep_exec,
    input logic                  cfg_stby,
    input logic                  cfg_lspd,
    input logic                  cfg_tclk,
    input logic                  irq_mask,
    input logic [NUM_SRC-1:0]    irq_req,
    input logic [NUM_SRC-1:0]    irq_en,
    input logic                  cpu_clk_en,
    input logic [NUM_PERIPH-1:0] periph_en,
    input logic                  hold_en,
    input logic                  exc_start
);
    logic good_cfg;
    assign good_cfg = !cfg_stby && cfg_lspd && cfg_tclk;

    a_r2_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_exec && good_cfg && cpu_clk_en && !exc_start) |=> !cpu_clk_en);

    a_r3_ignore_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_exec && !good_cfg && cpu_clk_en && !exc_start) |=> cpu_clk_en);

    a_r4_gate_pair: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_clk_en |-> (periph_en[1:0] == 2'b00 && &periph_en[NUM_PERIPH-1:2]));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold_en |-> (!cpu_clk_en && !exc_start));

    a_r8_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exc_start) |-> $past(!cpu_clk_en));

    a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        exc_start |=> (!exc_start && cpu_clk_en));

    a_r9_running: assert property (@(posedge clk) disable iff (!rst_n)
        exc_start |-> (cpu_clk_en && &periph_en));
endmodule

bind sslp_ctrl sslp_ctrl_chk #(.NUM_SRC(NUM_SRC), .NUM_PERIPH(NUM_PERIPH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_exec (sleep_exec),
    .cfg_stby   (cfg_stby),
    .cfg_lspd   (cfg_lspd),
    .cfg_tclk   (cfg_tclk),
    .irq_mask   (irq_mask),
    .irq_req    (irq_req),
    .irq_en     (irq_en),
    .cpu_clk_en (cpu_clk_en),
    .periph_en  (periph_en),
    .hold_en    (hold_en),
    .exc_start  (exc_start)
);

// File: tb/sim_sslp_ctrl.sv
`timescale 1ns/1ps
module sim_sslp_ctrl;
    localparam int NS = 18;
    localparam int NP = 8;
    localparam logic [NP-1:0] DOZE_PER = 8'b1111_1100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_exec = 1'b0;
    logic          cfg_stby = 1'b0, cfg_lspd = 1'b0, cfg_tclk = 1'b0;
    logic          irq_mask = 1'b0;
    logic [NS-1:0] irq_req = '0, irq_en = '0;
    logic          cpu_clk_en, hold_en, exc_start;
    logic [NP-1:0] periph_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sslp_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sleep_exec(sleep_exec),
        .cfg_stby(cfg_stby), .cfg_lspd(cfg_lspd), .cfg_tclk(cfg_tclk),
        .irq_mask(irq_mask), .irq_req(irq_req), .irq_en(irq_en),
        .cpu_clk_en(cpu_clk_en), .periph_en(periph_en),
        .hold_en(hold_en), .exc_start(exc_start)
    );

    function automatic bit want_enter(logic s, logic l, logic t);
        return !s && l && t;
    endfunction

    function automatic bit want_wake(logic m, logic [NS-1:0] r, logic [NS-1:0] e);
        return !m && ((r & e) != '0);
    endfunction

    // pack {cpu_clk_en, hold_en, exc_start, periph_en}
    task automatic expect_out(string req, logic c, logic h, logic x, logic [NP-1:0] p);
        checks++;
        if ({cpu_clk_en, hold_en, exc_start, periph_en} !== {c, h, x, p}) begin
            errors++;
            $display("FAIL %s: got clk=%b hold=%b exc=%b per=%b, exp clk=%b hold=%b exc=%b per=%b",
                     req, cpu_clk_en, hold_en, exc_start, periph_en, c, h, x, p);
        end
    endtask

    task automatic pulse_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic go_sleep();
        @(negedge clk);
        {cfg_stby, cfg_lspd, cfg_tclk} = 3'b011;
        sleep_exec = 1'b1;
        @(negedge clk);
        sleep_exec = 1'b0;
    endtask

    task automatic clear_irq();
        irq_req = '0; irq_en = '0; irq_mask = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got hung run, exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        expect_out("R1 in reset", 1, 0, 0, '1);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 after reset", 1, 0, 0, '1);

        // R2/R4/R5 directed entry
        go_sleep();
        expect_out("R2 R4 R5 entry", 0, 1, 0, DOZE_PER);

        // R11 strobe while asleep
        sleep_exec = 1'b1;
        repeat (2) @(negedge clk);
        sleep_exec = 1'b0;
        expect_out("R11 strobe asleep", 0, 1, 0, DOZE_PER);

        // R8 latency, R9 pulse width
        irq_req[5] = 1'b1; irq_en[5] = 1'b1;
        @(negedge clk);
        expect_out("R8 after 1 edge", 0, 1, 0, DOZE_PER);
        @(negedge clk);
        expect_out("R8 after 2 edges", 0, 1, 0, DOZE_PER);
        @(negedge clk);
        expect_out("R8 R6 exc after 3 edges", 1, 0, 1, '1);
        @(negedge clk);
        expect_out("R9 back to run", 1, 0, 0, '1);
        clear_irq();

        // R7 masked
        go_sleep();
        irq_mask = 1'b1; irq_req = '1; irq_en = '1;
        repeat (6) @(negedge clk);
        expect_out("R7 masked", 0, 1, 0, DOZE_PER);
        // R7 disabled source
        irq_mask = 1'b0; irq_en = '0;
        repeat (6) @(negedge clk);
        expect_out("R7 disabled", 0, 1, 0, DOZE_PER);

        // R10 async reset mid-sleep
        #1 rst_n = 1'b0;
        #1 expect_out("R10 async exit", 1, 0, 0, '1);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        expect_out("R10 no pulse", 1, 0, 0, '1);
        clear_irq();

        // R3 every wrong combination
        for (int c = 0; c < 8; c++) begin
            if (c == 3) continue;
            @(negedge clk);
            {cfg_stby, cfg_lspd, cfg_tclk} = 3'(c);
            sleep_exec = 1'b1;
            @(negedge clk);
            sleep_exec = 1'b0;
            expect_out("R3 wrong cfg", 1, 0, 0, '1);
        end

        // random mix
        for (int it = 0; it < 60; it++) begin
            logic [2:0] cf;
            bit ent, wk;
            cf = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 1) == 1) cf = 3'b011;
            @(negedge clk);
            {cfg_stby, cfg_lspd, cfg_tclk} = cf;
            sleep_exec = 1'b1;
            @(negedge clk);
            sleep_exec = 1'b0;
            ent = want_enter(cf[2], cf[1], cf[0]);
            if (!ent) begin
                expect_out("R3 random cfg", 1, 0, 0, '1);
                continue;
            end
            expect_out("R2 random entry", 0, 1, 0, DOZE_PER);
            irq_mask = ($urandom_range(0, 3) == 0);
            irq_req  = NS'($urandom) & NS'($urandom);
            irq_en   = NS'($urandom) & NS'($urandom);
            wk = want_wake(irq_mask, irq_req, irq_en);
            repeat (3) @(negedge clk);
            if (wk) begin
                expect_out("R6 random wake", 1, 0, 1, '1);
                @(negedge clk);
                expect_out("R9 random end", 1, 0, 0, '1);
            end else begin
                expect_out("R7 random stay", 0, 1, 0, DOZE_PER);
                pulse_reset();
            end
            clear_irq();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule